// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor's load/store port and a slower backing memory. Each word address is split into a tag, a set index and a word offset within the block. The index selects one set, and the tags of both ways in that set are compared against the request in the same cycle. A hit completes with no stall. A load returns its word one cycle after acceptance. A store updates the cached word and marks the block dirty.

On a miss the controller picks a victim way from a one-bit first-in first-out pointer kept per set. If the victim holds modified data, the whole block is first copied out to memory as a multi-beat burst. The requested block is then fetched in a burst of the same shape, and each beat occupies a fixed number of cycles. Stores that miss allocate the block the same way and then complete as hits. Storage is held in register arrays. The number of sets, the block length, the data width and the beat latency are all parameters.

Top module: `wb2_dcache`

## Requirements
- R1: The tags of both ways are compared in parallel with the request tag (upper address bits, above the index and offset fields). A valid match in either way is a hit: cpu_ready is high in the same cycle as cpu_valid, and at most one way ever matches.
- R2: A miss whose victim is invalid or clean stalls the request for exactly WORDS*BEAT_LAT+1 cycles. It reads the requested block in WORDS beats at ascending offsets 0..WORDS-1. Each beat holds mem_addr and mem_we stable for BEAT_LAT cycles, with mem_last high on the final cycle, when mem_rdata is captured.
- R3: A store hit sets the block's dirty bit. A miss whose victim is dirty first writes that block back in WORDS beats at ascending offsets, at the victim's own tag and index, and then refills. This stalls for 2*WORDS*BEAT_LAT+1 cycles. After the write-back, memory holds the stored data.
- R4: A store miss allocates the block, merges the store into it, and writes nothing to memory. A later load returns the stored value.
- R5: Each set's victim pointer selects way 0 after reset and toggles only when a block is allocated into that set, never on a hit. The block that was allocated first is therefore evicted first, even if it was used more recently.
- R6: While reset is low, cpu_ready, cpu_rvalid and mem_en are low. After reset all blocks are invalid, so the first access to any block misses.
- R7: Evicting a clean or invalid victim produces no memory write beats.
- R8: cpu_rvalid is high exactly in the cycle after a request is accepted. For a load, cpu_rdata then holds the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request present; held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_rvalid | output | 1 | Completion, one cycle after acceptance |
| cpu_rdata | output | DATA_W | Load data |
| mem_en | output | 1 | A memory beat is in progress |
| mem_we | output | 1 | Beat is a write-back (1) or a refill read (0) |
| mem_last | output | 1 | Final cycle of the current beat |
| mem_addr | output | ADDR_W | Word address of the current beat |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Refill data, sampled when mem_last is high |

## Verification
Two operations share a single cycle: the final refill beat writes the last word of the block, and in the same clock edge the tag is installed, the dirty bit is cleared and the set's victim pointer advances. The test provokes this by following every miss immediately with further traffic to the same set. A block that is re-accessed must hit, and the next miss in that set must take the other way. Both the stall count and the data are predicted by a reference model in the test. The same model predicts dirty write-backs that run straight into a refill, and it checks their beat count, address and the contents of memory afterwards.

// File: rtl/wb2_pkg.sv
package wb2_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_WBACK  = 2'd1,
    ST_REFILL = 2'd2
  } wb2_state_e;

  localparam int NUM_WAYS = 2;
endpackage

// File: rtl/wb2_tag_store.sv
module wb2_tag_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 10,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       way_hit,
  output logic             vic_way,
  output logic             vic_valid,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             alloc_way,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             mark_way
);
  logic [SETS-1:0]  vld [wb2_pkg::NUM_WAYS];
  logic [SETS-1:0]  dty [wb2_pkg::NUM_WAYS];
  logic [TAG_W-1:0] tags [wb2_pkg::NUM_WAYS][SETS];
  logic [SETS-1:0]  fifo_ptr;

  // parallel compare, one comparator per way
  for (genvar w = 0; w < wb2_pkg::NUM_WAYS; w++) begin : g_cmp
    assign way_hit[w] = vld[w][lk_idx] && (tags[w][lk_idx] == lk_tag);
  end

  assign vic_way   = fifo_ptr[lk_idx];
  assign vic_valid = vld[vic_way][lk_idx];
  assign vic_dirty = dty[vic_way][lk_idx];
  assign vic_tag   = tags[vic_way][lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < wb2_pkg::NUM_WAYS; w++) begin
        vld[w] <= '0;
        dty[w] <= '0;
      end
      fifo_ptr <= '0;
    end else begin
      if (alloc_en) begin
        vld[alloc_way][alloc_idx] <= 1'b1;
        dty[alloc_way][alloc_idx] <= 1'b0;
        fifo_ptr[alloc_idx]       <= ~fifo_ptr[alloc_idx];
      end else if (mark_en) begin
        dty[mark_way][mark_idx]   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tags[alloc_way][alloc_idx] <= alloc_tag;
    end
  end
endmodule

// File: rtl/wb2_data_store.sv
module wb2_data_store #(
  parameter int SETS   = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(SETS),
  parameter int OFF_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_way,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] words [wb2_pkg::NUM_WAYS][SETS][WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      words[wr_way][wr_idx][wr_off] <= wr_data;
    end
  end

  assign rd_data = words[rd_way][rd_idx][rd_off];
endmodule

// File: rtl/wb2_burst.sv
module wb2_burst #(
  parameter int WORDS    = 4,
  parameter int BEAT_LAT = 5,
  parameter int OFF_W    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [OFF_W-1:0] beat,
  output logic             beat_end,
  output logic             burst_end
);
  localparam int CYC_W = (BEAT_LAT > 1) ? $clog2(BEAT_LAT) : 1;

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [OFF_W-1:0] beat_q, beat_d;

  assign beat      = beat_q;
  assign beat_end  = run && (cyc_q == CYC_W'(BEAT_LAT - 1));
  assign burst_end = beat_end && (beat_q == OFF_W'(WORDS - 1));

  always_comb begin
    cyc_d  = cyc_q;
    beat_d = beat_q;
    if (!run) begin
      cyc_d  = '0;
      beat_d = '0;
    end else if (beat_end) begin
      cyc_d  = '0;
      beat_d = burst_end ? '0 : beat_q + 1'b1;
    end else begin
      cyc_d  = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      beat_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      beat_q <= beat_d;
    end
  end
endmodule

// File: rtl/wb2_dcache.sv
module wb2_dcache #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int SETS     = 16,
  parameter int WORDS    = 4,
  parameter int BEAT_LAT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic              mem_last,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  import wb2_pkg::*;

  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  // address fields
  logic [OFF_W-1:0] cpu_off;
  logic [IDX_W-1:0] cpu_idx;
  logic [TAG_W-1:0] cpu_tag;
  assign cpu_off = cpu_addr[OFF_W-1:0];
  assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
  assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  wb2_state_e       state_q, state_d;
  logic [TAG_W-1:0] req_tag_q, req_tag_d;
  logic [IDX_W-1:0] req_idx_q, req_idx_d;
  logic             vic_way_q, vic_way_d;
  logic [TAG_W-1:0] vic_tag_q, vic_tag_d;
  logic [DATA_W-1:0] rdata_q;
  logic             rvalid_q;

  logic [1:0]       way_hit;
  logic             hit_way;
  logic             vic_way, vic_valid, vic_dirty;
  logic [TAG_W-1:0] vic_tag;
  logic             accept, miss_take;
  logic             in_lookup, in_wback, in_refill;

  logic [OFF_W-1:0] beat;
  logic             beat_end, burst_end;

  logic              dw_en, dw_way, dr_way;
  logic [IDX_W-1:0]  dw_idx, dr_idx;
  logic [OFF_W-1:0]  dw_off, dr_off;
  logic [DATA_W-1:0] dw_data, dr_data;

  assign in_lookup = (state_q == ST_LOOKUP);
  assign in_wback  = (state_q == ST_WBACK);
  assign in_refill = (state_q == ST_REFILL);
  assign hit_way   = way_hit[1];
  assign accept    = in_lookup && cpu_valid && (|way_hit);
  assign miss_take = in_lookup && cpu_valid && !(|way_hit);

  wb2_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (cpu_idx),
    .lk_tag    (cpu_tag),
    .way_hit   (way_hit),
    .vic_way   (vic_way),
    .vic_valid (vic_valid),
    .vic_dirty (vic_dirty),
    .vic_tag   (vic_tag),
    .alloc_en  (in_refill && burst_end),
    .alloc_idx (req_idx_q),
    .alloc_way (vic_way_q),
    .alloc_tag (req_tag_q),
    .mark_en   (accept && cpu_we),
    .mark_idx  (cpu_idx),
    .mark_way  (hit_way)
  );

  wb2_burst #(.WORDS(WORDS), .BEAT_LAT(BEAT_LAT), .OFF_W(OFF_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (!in_lookup),
    .beat      (beat),
    .beat_end  (beat_end),
    .burst_end (burst_end)
  );

  // data array port steering
  always_comb begin
    dw_en   = (accept && cpu_we) || (in_refill && beat_end);
    dw_way  = in_refill ? vic_way_q : hit_way;
    dw_idx  = in_refill ? req_idx_q : cpu_idx;
    dw_off  = in_refill ? beat      : cpu_off;
    dw_data = in_refill ? mem_rdata : cpu_wdata;
    dr_way  = in_wback  ? vic_way_q : hit_way;
    dr_idx  = in_wback  ? req_idx_q : cpu_idx;
    dr_off  = in_wback  ? beat      : cpu_off;
  end

  wb2_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W),
                   .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk     (clk),
    .wr_en   (dw_en),
    .wr_way  (dw_way),
    .wr_idx  (dw_idx),
    .wr_off  (dw_off),
    .wr_data (dw_data),
    .rd_way  (dr_way),
    .rd_idx  (dr_idx),
    .rd_off  (dr_off),
    .rd_data (dr_data)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    req_tag_d = req_tag_q;
    req_idx_d = req_idx_q;
    vic_way_d = vic_way_q;
    vic_tag_d = vic_tag_q;
    unique case (state_q)
      ST_LOOKUP: begin
        if (miss_take) begin
          req_tag_d = cpu_tag;
          req_idx_d = cpu_idx;
          vic_way_d = vic_way;
          vic_tag_d = vic_tag;
          state_d   = (vic_valid && vic_dirty) ? ST_WBACK : ST_REFILL;
        end
      end
      ST_WBACK:  if (burst_end) state_d = ST_REFILL;
      ST_REFILL: if (burst_end) state_d = ST_LOOKUP;
      default:   state_d = ST_LOOKUP;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_LOOKUP;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= accept;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (miss_take) begin
      req_tag_q <= req_tag_d;
      req_idx_q <= req_idx_d;
      vic_way_q <= vic_way_d;
      vic_tag_q <= vic_tag_d;
    end
    if (accept) begin
      rdata_q <= dr_data;
    end
  end

  assign cpu_ready  = accept;
  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

  assign mem_en    = !in_lookup;
  assign mem_we    = in_wback;
  assign mem_last  = beat_end;
  assign mem_addr  = in_wback ? {vic_tag_q, req_idx_q, beat}
                              : {req_tag_q, req_idx_q, beat};
  assign mem_wdata = dr_data;
endmodule

// File: rtl/wb2_dcache_chk.sv
module wb2_dcache_chk #(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              mem_en,
  input logic              mem_we,
  input logic              mem_last,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        way_hit
);
  localparam int OFF_W = $clog2(WORDS);

  logic last_word;
  assign last_word = (mem_addr[OFF_W-1:0] == OFF_W'(WORDS - 1));

  // R1: never two matching ways
  p_one_way_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R2: beat address and direction held until the beat's last cycle
  p_beat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_last) |=> (mem_en && $stable(mem_addr) && $stable(mem_we)));

  // R2: no acceptance while the memory port is busy
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !cpu_ready);

  // R2: final refill beat ends the memory activity
  p_refill_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && mem_last && last_word) |=> !mem_en);

  // R3: write-back is always followed by a refill
  p_wb_then_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mem_last && last_word) |=> (mem_en && !mem_we));

  // R8: completion strobe follows acceptance, and only acceptance
  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready) |=> cpu_rvalid);
  p_noack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_ready) |=> !cpu_rvalid);
endmodule

bind wb2_dcache wb2_dcache_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_valid  (cpu_valid),
  .cpu_ready  (cpu_ready),
  .cpu_rvalid (cpu_rvalid),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_last   (mem_last),
  .mem_addr   (mem_addr),
  .way_hit    (way_hit)
);

// File: tb/wb2_dcache_tb_top.sv
module wb2_dcache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int SETS     = 4;
  localparam int WORDS    = 4;
  localparam int BEAT_LAT = 5;
  localparam int OFF_W    = $clog2(WORDS);
  localparam int IDX_W    = $clog2(SETS);
  localparam int MEM_N    = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_valid, cpu_we;
  logic [ADDR_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata;
  logic cpu_ready, cpu_rvalid;
  logic [DATA_W-1:0] cpu_rdata;
  logic mem_en, mem_we, mem_last;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb2_dcache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS),
               .WORDS(WORDS), .BEAT_LAT(BEAT_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_last(mem_last), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // backing memory model
  logic [DATA_W-1:0] mem_model [MEM_N];
  logic [DATA_W-1:0] golden    [MEM_N];
  int wr_cnt = 0, rd_cnt = 0;
  int last_wr_blk = -1, last_rd_blk = -1;
  bit order_bad = 1'b0;

  assign mem_rdata = mem_model[mem_addr];

  always @(posedge clk) begin
    if (mem_en && mem_last) begin
      if (mem_we) begin
        mem_model[mem_addr] <= mem_wdata;
        if (int'(mem_addr[OFF_W-1:0]) != wr_cnt % WORDS) order_bad <= 1'b1;
        wr_cnt      <= wr_cnt + 1;
        last_wr_blk <= int'(mem_addr) >> OFF_W;
      end else begin
        if (int'(mem_addr[OFF_W-1:0]) != rd_cnt % WORDS) order_bad <= 1'b1;
        rd_cnt      <= rd_cnt + 1;
        last_rd_blk <= int'(mem_addr) >> OFF_W;
      end
    end
  end

  // reference cache state
  bit rv [2][SETS];
  bit rdty [2][SETS];
  int rt [2][SETS];
  bit rp [SETS];

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one CPU access; override labels the stall check when not empty
  task automatic acc(input bit we, input int addr, input logic [DATA_W-1:0] wd,
                     input string override);
    int idx, tag, blk, vw, vblk, exp_stall, stall, w0, r0;
    bit hit, dv;
    string lbl;
    idx = (addr >> OFF_W) % SETS;
    tag = addr >> (OFF_W + IDX_W);
    blk = addr >> OFF_W;
    hit = 1'b0;
    for (int w = 0; w < 2; w++) if (rv[w][idx] && rt[w][idx] == tag) hit = 1'b1;
    vw   = int'(rp[idx]);
    dv   = !hit && rv[vw][idx] && rdty[vw][idx];
    vblk = (rt[vw][idx] << IDX_W) | idx;
    exp_stall = hit ? 0 : (dv ? 2*WORDS*BEAT_LAT + 1 : WORDS*BEAT_LAT + 1);
    lbl = (override != "") ? override : (hit ? "R1" : (dv ? "R3" : "R2"));
    w0 = wr_cnt; r0 = rd_cnt;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
    #1;
    stall = 0;
    while (!cpu_ready && stall < 1000) begin
      @(negedge clk);
      stall++;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    chk({lbl, " stall cycles"}, 64'(stall), 64'(exp_stall));
    chk("R8 rvalid after accept", 64'(cpu_rvalid), 64'd1);
    if (!we) chk("R1 R4 load data", 64'(cpu_rdata), 64'(golden[addr]));
    chk("R2 refill beat count", 64'(rd_cnt - r0), 64'(hit ? 0 : WORDS));
    chk(dv ? "R3 write-back beat count" : "R7 no write beats",
        64'(wr_cnt - w0), 64'(dv ? WORDS : 0));
    if (!hit) begin
      chk("R2 refill block address", 64'(last_rd_blk), 64'(blk));
      chk("R2 beat offset order", 64'(order_bad), 64'd0);
    end
    if (dv) begin
      chk("R3 write-back block address", 64'(last_wr_blk), 64'(vblk));
      for (int k = 0; k < WORDS; k++)
        chk("R3 memory after write-back", 64'(mem_model[vblk*WORDS + k]),
            64'(golden[vblk*WORDS + k]));
    end
    if (!hit) begin
      rv[vw][idx] = 1'b1; rt[vw][idx] = tag; rdty[vw][idx] = 1'b0;
      rp[idx] = ~rp[idx];
    end
    if (we) begin
      golden[addr] = wd;
      for (int w = 0; w < 2; w++)
        if (rv[w][idx] && rt[w][idx] == tag) rdty[w][idx] = 1'b1;
    end
  endtask

  function automatic int a_of(input int tag, input int set, input int off);
    return (tag << (OFF_W + IDX_W)) | (set << OFF_W) | off;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lcg;
    for (int i = 0; i < MEM_N; i++) begin
      mem_model[i] = DATA_W'(i) * 32'h0100_0193 + 32'hC0DE_0000;
      golden[i]    = mem_model[i];
    end
    for (int s = 0; s < SETS; s++) begin
      rp[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin rv[w][s] = 1'b0; rdty[w][s] = 1'b0; rt[w][s] = 0; end
    end
    rst_n = 1'b0; cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    // R6: outputs quiet during reset even with a request pending
    chk("R6 ready in reset",  64'(cpu_ready),  64'd0);
    chk("R6 rvalid in reset", 64'(cpu_rvalid), 64'd0);
    chk("R6 mem_en in reset", 64'(mem_en),     64'd0);
    cpu_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R6: first touch of every block misses; sweep two tags per set, every word
    acc(1'b0, 0, '0, "R6");
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < SETS; s++)
        for (int o = 0; o < WORDS; o++)
          acc(1'b0, a_of(t, s, o), '0, "");
    // R1: all resident, re-read hits
    for (int a = 0; a < 2*SETS*WORDS; a++) acc(1'b0, a, '0, "R1");

    // R3: dirty tag-0 blocks by store hits
    for (int s = 0; s < SETS; s++)
      for (int o = 0; o < WORDS; o++)
        acc(1'b1, a_of(0, s, o), 32'hA500_0000 | DATA_W'(s*16 + o), "R1");

    // R5: hits on tag 0 must not protect it; tag 2 evicts tag 0 (oldest)
    for (int s = 0; s < SETS; s++) begin
      acc(1'b0, a_of(0, s, 1), '0, "R5");
      acc(1'b0, a_of(2, s, 0), '0, "R3");
      acc(1'b0, a_of(1, s, 2), '0, "R5");
      acc(1'b0, a_of(0, s, 3), '0, "R5");
    end

    // R4: store misses allocate, then load back
    for (int s = 0; s < SETS; s++) begin
      acc(1'b1, a_of(3, s, s % WORDS), 32'h5700_0000 | DATA_W'(s), "");
      acc(1'b0, a_of(3, s, s % WORDS), '0, "R4");
    end

    // mixed sweep over four tags
    lcg = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 1103515245 + 12345;
      acc(lcg[20], (lcg >>> 8) & (4*SETS*WORDS - 1), DATA_W'(lcg), "");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule